// File: doc/BRIEF.md
# Configuration Address Port Translator

This block sits on the host side of a chip and implements the legacy two-port I/O method for reaching PCI configuration space. Software first writes a 32-bit selector word into an address port, then reads or writes a four-byte data window. The block sorts each processor I/O request into one of three kinds: an access to the selector latch, a configuration access through the data window, or an ordinary I/O cycle to pass downstream.

Data-window accesses made while the selector's enable bit is set become configuration requests. A request is encoded for a device on the local bus (bus number zero) or for a bridge to forward (any other bus number). Each forwarded request leaves through a valid/ready port. The response, or all ones for an unclaimed read, comes back to the processor side as a single-cycle completion. The block takes one request at a time.

Top module: `cfg_port_xlate`

## Requirements
- R1: After reset the selector latch is 00000000h, `up_ready` is high, and `dn_valid` and `rsp_valid` are low.
- R2: A write to the address port (byte address 0CF8h to 0CFBh, dword-aligned match) with all four byte enables set loads the latch and sends nothing downstream. Bits 30:24 and 1:0 are stored as zero. A full-dword read returns the latch, has no side effect, and sends nothing downstream.
- R3: An access to the address port with any byte enable clear leaves the latch unchanged. It is forwarded as a plain I/O cycle (`dn_kind` = 00) with `dn_ad` = the zero-extended byte address and the same byte enables.
- R4: With latch bit 31 clear, an access to the data window (0CFCh to 0CFFh) is forwarded as a plain I/O cycle (`dn_kind` = 00, `dn_ad` = zero-extended byte address).
- R5: With bit 31 set and latch bits 23:16 equal to zero, a data-window access is sent with `dn_kind` = 01 (local). `dn_ad[31:16]` is zero, `dn_ad[15:2]` copies latch bits 15:2 (device, function, register), and `dn_ad[1:0]` = 00.
- R6: With bit 31 set and bits 23:16 non-zero, a data-window access is sent with `dn_kind` = 10 (forwarded). `dn_ad[31:24]` is zero, `dn_ad[23:2]` copies latch bits 23:2, and `dn_ad[1:0]` = 01.
- R7: Every forwarded request carries the processor's byte enables, write flag and write data unchanged.
- R8: A forwarded read completes with `dn_rdata` if `dn_claim` is high at the handshake, and with FFFFFFFFh if it is low. Writes complete with zero data.
- R9: Any other I/O address is forwarded as a plain I/O cycle with its address and byte enables.
- R10: `dn_valid` and its fields stay steady until `dn_ready`. `up_ready` is low while a request is outstanding. Each accepted request produces exactly one single-cycle `rsp_valid`: one cycle after acceptance for latch accesses, one cycle after the downstream handshake otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| up_valid | input | 1 | Processor I/O request present |
| up_ready | output | 1 | Block can take a request |
| up_addr | input | 16 | I/O byte address |
| up_be | input | 4 | Byte enables |
| up_write | input | 1 | 1 = write, 0 = read |
| up_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Completion pulse |
| rsp_rdata | output | 32 | Completion read data |
| dn_valid | output | 1 | Downstream request present |
| dn_ready | input | 1 | Downstream accepts request |
| dn_kind | output | 2 | 00 I/O, 01 local config, 10 forwarded config |
| dn_ad | output | 32 | Address-phase value |
| dn_be | output | 4 | Byte enables |
| dn_write | output | 1 | Write flag |
| dn_wdata | output | 32 | Write data |
| dn_claim | input | 1 | Target claimed the cycle (sampled at handshake) |
| dn_rdata | input | 32 | Read data (sampled at handshake) |

## Verification
The assertions take for granted that `dn_ready` and `dn_claim` are only meaningful while `dn_valid` is high. They also assume the processor side offers a request only when it is ready to wait for its completion. The stimulus drives every request from a task that holds `up_valid` for exactly the accepting cycle. It raises `dn_ready` only after `dn_valid` has been seen, sometimes after a stall of several cycles, and it sets claim and read data in the same cycle as ready.

// File: rtl/cfg_port_xlate.sv
module cfg_port_xlate #(
  parameter int AW = 16,
  parameter logic [AW-1:0] ADDR_PORT = 16'h0CF8,
  parameter logic [AW-1:0] DATA_PORT = 16'h0CFC
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          up_valid,
  output logic          up_ready,
  input  logic [AW-1:0] up_addr,
  input  logic [3:0]    up_be,
  input  logic          up_write,
  input  logic [31:0]   up_wdata,
  output logic          rsp_valid,
  output logic [31:0]   rsp_rdata,
  output logic          dn_valid,
  input  logic          dn_ready,
  output logic [1:0]    dn_kind,
  output logic [31:0]   dn_ad,
  output logic [3:0]    dn_be,
  output logic          dn_write,
  output logic [31:0]   dn_wdata,
  input  logic          dn_claim,
  input  logic [31:0]   dn_rdata
);
  localparam logic [1:0] K_IO = 2'b00, K_LOCAL = 2'b01, K_FWD = 2'b10;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_RESP} st_t;
  st_t st;
  logic [31:0] sel_q;

  wire on_addr  = up_addr[AW-1:2] == ADDR_PORT[AW-1:2];
  wire on_win   = up_addr[AW-1:2] == DATA_PORT[AW-1:2];
  wire sel_hit  = on_addr & (&up_be);
  wire cfg_hit  = on_win & sel_q[31];
  wire far_bus  = |sel_q[23:16];
  wire take     = up_valid & up_ready;

  logic [1:0]  kind_n;
  logic [31:0] ad_n;

  always_comb begin
    kind_n = K_IO;
    ad_n   = 32'(up_addr);
    if (cfg_hit) begin
      if (far_bus) begin
        kind_n = K_FWD;
        ad_n   = {8'h00, sel_q[23:2], 2'b01};
      end else begin
        kind_n = K_LOCAL;
        ad_n   = {16'h0000, sel_q[15:2], 2'b00};
      end
    end
  end

  assign up_ready  = st == S_IDLE;
  assign dn_valid  = st == S_ISSUE;
  assign rsp_valid = st == S_RESP;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      sel_q     <= '0;
      rsp_rdata <= '0;
      dn_kind   <= K_IO;
      dn_ad     <= '0;
      dn_be     <= '0;
      dn_write  <= 1'b0;
      dn_wdata  <= '0;
    end else begin
      unique case (st)
        S_IDLE: if (take) begin
          if (sel_hit) begin
            if (up_write) sel_q <= {up_wdata[31], 7'b0, up_wdata[23:2], 2'b00};
            rsp_rdata <= up_write ? 32'h0 : sel_q;
            st        <= S_RESP;
          end else begin
            dn_kind  <= kind_n;
            dn_ad    <= ad_n;
            dn_be    <= up_be;
            dn_write <= up_write;
            dn_wdata <= up_wdata;
            st       <= S_ISSUE;
          end
        end
        S_ISSUE: if (dn_ready) begin
          rsp_rdata <= dn_write ? 32'h0 : (dn_claim ? dn_rdata : 32'hFFFF_FFFF);
          st        <= S_RESP;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

module cfg_port_xlate_chk #(
  parameter int AW = 16,
  parameter logic [AW-1:0] ADDR_PORT = 16'h0CF8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          up_valid,
  input logic          up_ready,
  input logic [AW-1:0] up_addr,
  input logic [3:0]    up_be,
  input logic          dn_valid,
  input logic          dn_ready,
  input logic [1:0]    dn_kind,
  input logic [31:0]   dn_ad,
  input logic [3:0]    dn_be,
  input logic          dn_write,
  input logic          dn_claim,
  input logic          rsp_valid,
  input logic [31:0]   rsp_rdata
);
  wire acc_addr = up_valid && up_ready && up_addr[AW-1:2] == ADDR_PORT[AW-1:2];

  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && !dn_ready |=> dn_valid && $stable(dn_ad) && $stable(dn_kind) && $stable(dn_be));
  assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid |-> !up_ready);
  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  assert_local_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_kind == 2'b01 |-> dn_ad[1:0] == 2'b00 && dn_ad[31:16] == 16'h0);
  assert_fwd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_kind == 2'b10 |-> dn_ad[1:0] == 2'b01 && dn_ad[31:24] == 8'h0 && dn_ad[23:16] != 8'h0);
  assert_narrow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc_addr && up_be != 4'hF |=> dn_valid && dn_kind == 2'b00);
  assert_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc_addr && up_be == 4'hF |=> rsp_valid && !dn_valid);
  assert_unclaimed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dn_valid && dn_ready && !dn_write && !dn_claim |=> rsp_valid && rsp_rdata == 32'hFFFF_FFFF);
endmodule

bind cfg_port_xlate cfg_port_xlate_chk #(.AW(AW), .ADDR_PORT(ADDR_PORT)) u_chk (.*);

// File: tb/cfg_port_xlate_bench.sv
module cfg_port_xlate_bench;
  logic clk = 0, rst_n = 0;
  logic up_valid = 0, up_write = 0, dn_ready = 0, dn_claim = 0;
  logic [15:0] up_addr = 0;
  logic [3:0] up_be = 0;
  logic [31:0] up_wdata = 0, dn_rdata = 0;
  logic up_ready, rsp_valid, dn_valid, dn_write;
  logic [31:0] rsp_rdata, dn_ad, dn_wdata;
  logic [1:0] dn_kind;
  logic [3:0] dn_be;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  cfg_port_xlate u_cfg_port_xlate (.*);

  typedef struct packed {
    logic [15:0] a; logic [3:0] be; logic wr; logic [31:0] wd;
    logic clm; logic [31:0] drd;
    logic xdn; logic [1:0] xk; logic [31:0] xad; logic [31:0] xrd;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{16'h0CF8,4'hF,1'b0,32'h0,        1'b0,32'h0,        1'b0,2'b00,32'h0,        32'h0,        4'd1}, // R1
    '{16'h0CFC,4'hF,1'b0,32'h0,        1'b0,32'h0,        1'b1,2'b00,32'h0000_0CFC,32'hFFFF_FFFF,4'd4}, // R4 R8
    '{16'h0CF8,4'hF,1'b1,32'hFFFF_FFFF,1'b0,32'h0,        1'b0,2'b00,32'h0,        32'h0,        4'd2}, // R2
    '{16'h0CF8,4'hF,1'b0,32'h0,        1'b0,32'h0,        1'b0,2'b00,32'h0,        32'h80FF_FFFC,4'd2}, // R2
    '{16'h0CF8,4'hF,1'b1,32'h8000_5A14,1'b0,32'h0,        1'b0,2'b00,32'h0,        32'h0,        4'd2}, // R2
    '{16'h0CFE,4'h4,1'b0,32'h0,        1'b1,32'h1234_5678,1'b1,2'b01,32'h0000_5A14,32'h1234_5678,4'd5}, // R5 R7
    '{16'h0CFC,4'hF,1'b1,32'hDEAD_BEEF,1'b1,32'h0,        1'b1,2'b01,32'h0000_5A14,32'h0,        4'd7}, // R7
    '{16'h0CF8,4'hF,1'b1,32'h8103_2A0B,1'b0,32'h0,        1'b0,2'b00,32'h0,        32'h0,        4'd2}, // R2
    '{16'h0CF8,4'hF,1'b0,32'h0,        1'b0,32'h0,        1'b0,2'b00,32'h0,        32'h8003_2A08,4'd2}, // R2
    '{16'h0CFC,4'h3,1'b0,32'h0,        1'b1,32'h0000_BEEF,1'b1,2'b10,32'h0003_2A09,32'h0000_BEEF,4'd6}, // R6
    '{16'h0CF8,4'h3,1'b1,32'h0,        1'b1,32'h0,        1'b1,2'b00,32'h0000_0CF8,32'h0,        4'd3}, // R3
    '{16'h0CF8,4'hF,1'b0,32'h0,        1'b0,32'h0,        1'b0,2'b00,32'h0,        32'h8003_2A08,4'd3}, // R3
    '{16'h0080,4'h1,1'b0,32'h0,        1'b1,32'h0000_00A5,1'b1,2'b00,32'h0000_0080,32'h0000_00A5,4'd9}, // R9
    '{16'h0CFA,4'hC,1'b0,32'h0,        1'b0,32'h0,        1'b1,2'b00,32'h0000_0CFA,32'hFFFF_FFFF,4'd3}, // R3
    '{16'h0CF8,4'hF,1'b1,32'h0,        1'b0,32'h0,        1'b0,2'b00,32'h0,        32'h0,        4'd2}, // R2
    '{16'h0CFF,4'h8,1'b1,32'h7700_0000,1'b1,32'h0,        1'b1,2'b00,32'h0000_0CFF,32'h0,        4'd4}, // R4
    '{16'h0CFC,4'hF,1'b0,32'h0,        1'b1,32'h5555_AAAA,1'b1,2'b00,32'h0000_0CFC,32'h5555_AAAA,4'd8}  // R8
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xact(input logic [15:0] a, input logic [3:0] be, input logic wr, input logic [31:0] wd,
                      input int dly, input logic clm, input logic [31:0] drd,
                      output bit saw, output logic [1:0] k, output logic [31:0] ad, output logic [3:0] obe,
                      output logic ow, output logic [31:0] owd, output logic [31:0] rd, output bit steady);
    int cnt = 0;
    saw = 0; steady = 1; rd = 'x; k = 0; ad = 0; obe = 0; ow = 0; owd = 0;
    @(negedge clk);
    up_valid = 1; up_addr = a; up_be = be; up_write = wr; up_wdata = wd;
    @(negedge clk);
    up_valid = 0;
    for (int i = 0; i < 60; i++) begin
      if (rsp_valid) begin rd = rsp_rdata; break; end
      if (dn_valid) begin
        if (up_ready) steady = 0;
        if (!saw) begin
          saw = 1; k = dn_kind; ad = dn_ad; obe = dn_be; ow = dn_write; owd = dn_wdata;
        end else if (dn_ad !== ad || dn_kind !== k || dn_be !== obe) steady = 0;
        if (cnt == dly) begin dn_ready = 1; dn_claim = clm; dn_rdata = drd; end
        cnt++;
      end
      @(negedge clk);
      dn_ready = 0; dn_claim = 0; dn_rdata = 0;
    end
    @(negedge clk);
    if (rsp_valid) steady = 0;
  endtask

  initial begin
    bit saw, st;
    logic [1:0] k; logic [31:0] ad, owd, rd; logic [3:0] obe; logic ow;
    repeat (3) @(negedge clk);
    // R1: reset outputs
    chk(up_ready === 1 && dn_valid === 0 && rsp_valid === 0, "R1 reset outputs",
        {29'b0, up_ready, dn_valid, rsp_valid}, 32'h4);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      xact(VEC[i].a, VEC[i].be, VEC[i].wr, VEC[i].wd, i % 3, VEC[i].clm, VEC[i].drd,
           saw, k, ad, obe, ow, owd, rd, st);
      chk(saw == VEC[i].xdn, $sformatf("R%0d vec%0d downstream-present", VEC[i].req, i), 32'(saw), 32'(VEC[i].xdn));
      chk(rd === VEC[i].xrd, $sformatf("R%0d vec%0d completion data", VEC[i].req, i), rd, VEC[i].xrd);
      chk(st, $sformatf("R10 vec%0d handshake", i), 32'(st), 32'h1);
      if (VEC[i].xdn) begin
        chk(k === VEC[i].xk, $sformatf("R%0d vec%0d kind", VEC[i].req, i), 32'(k), 32'(VEC[i].xk));
        chk(ad === VEC[i].xad, $sformatf("R%0d vec%0d address", VEC[i].req, i), ad, VEC[i].xad);
        // R7: pass-through of enables, write flag and data
        chk(obe === VEC[i].be && ow === VEC[i].wr && owd === VEC[i].wd,
            $sformatf("R7 vec%0d passthrough", i), owd, VEC[i].wd);
      end
    end

    // R10: long stall keeps request steady and gives one completion
    xact(16'h0CFC, 4'hF, 1'b0, 32'h0, 5, 1'b1, 32'hCAFE_0001, saw, k, ad, obe, ow, owd, rd, st);
    chk(st && saw, "R10 stalled handshake", 32'(st), 32'h1);
    chk(rd === 32'hCAFE_0001, "R10 stalled completion", rd, 32'hCAFE_0001);

    // R1: reset clears a loaded latch
    xact(16'h0CF8, 4'hF, 1'b1, 32'h8012_3404, 0, 1'b0, 32'h0, saw, k, ad, obe, ow, owd, rd, st);
    @(negedge clk); rst_n = 0; @(negedge clk); @(negedge clk); rst_n = 1;
    xact(16'h0CF8, 4'hF, 1'b0, 32'h0, 0, 1'b0, 32'h0, saw, k, ad, obe, ow, owd, rd, st);
    chk(rd === 32'h0 && !saw, "R1 latch cleared by reset", rd, 32'h0);
    // R4: after reset window is plain I/O again
    xact(16'h0CFD, 4'h2, 1'b0, 32'h0, 1, 1'b0, 32'h0, saw, k, ad, obe, ow, owd, rd, st);
    chk(saw && k === 2'b00 && ad === 32'h0000_0CFD, "R4 window disabled after reset", ad, 32'h0000_0CFD);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule